// File: doc/BRIEF.md
# Wrapping Stack Pointer and Context Sequencer

This block keeps the stack pointer of a small 8-bit processor and moves stack bytes to and from a byte-wide memory. The pointer is 16 bits wide. Only its low seven bits are state; the upper nine bits are fixed. The stack is therefore a 128-byte window from 0x0180 to 0x01FF. When the pointer runs past either end of the window, it wraps to the other end without raising any flag.

A caller starts an operation with a 3-bit command code. The operations are a single-byte push or pop, a two-byte subroutine call or return, a five-byte interrupt entry or interrupt return, and a stack reset. The sequencer captures the program counter, index, accumulator and condition byte when it accepts the command. It then moves one byte per memory handshake and reports each popped byte with a destination tag. Software can also write and read the low pointer byte directly.

Top module: `stackPtrUnit`

## Requirements
- R1: After reset the pointer reads 0x01FF, `busy` is low, and neither memory enable is asserted.
- R2: Pointer bits 15..7 always read 0x0180 >> 7. Every memory access targets an address in 0x0180..0x01FF.
- R3: A push (code 1) writes `pushData` at the address the pointer holds and then decrements the pointer by one.
- R4: A pop (code 2) reads the address one above the pointer and leaves the pointer there. The byte appears on `popData` with `popValid` high and `popDest` = 5 one cycle after the handshake completes.
- R5: A decrement from 0x0180 gives 0x01FF, and an increment from 0x01FF gives 0x0180, with no indication of either.
- R6: The stack-reset code (7) sets pointer bits 6..0 to all ones on the next clock edge.
- R7: When `spLoWr` is high, the block is idle and the code is 0, bits 6..0 of `spLoWdata` are loaded into the pointer and bit 7 of `spLoWdata` has no effect. `spLo` always shows pointer bits 7..0.
- R8: A call (code 3) stores the low PC byte at the pointer and the high PC byte one below it, leaving the pointer two lower. A return (code 4) pops the high PC byte (dest 1) and then the low PC byte (dest 0).
- R9: An interrupt entry (code 5) stores the low PC byte, high PC byte, X, A and CC at successively lower addresses, leaving the pointer five lower. An interrupt return (code 6) pops CC, A, X, high PC and low PC, with dest 4, 3, 2, 1, 0 in that order.
- R10: `busy` rises on the edge that accepts codes 1..6 and falls on the edge that completes the final byte. While `busy` is high, all codes and low-byte writes are ignored.
- R11: Each memory request holds its address and enable steady until `memDone`, moves exactly one byte per `memDone`, and never asserts write and read together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opCode | input | 3 | Command: 0 none, 1 push, 2 pop, 3 call, 4 return, 5 interrupt, 6 interrupt return, 7 stack reset |
| pushData | input | 8 | Byte for a single push |
| pcIn | input | 16 | Program counter to save |
| xIn | input | 8 | Index register to save |
| aIn | input | 8 | Accumulator to save |
| ccIn | input | 8 | Condition byte to save |
| spLoWr | input | 1 | Direct write strobe for the low pointer byte |
| spLoWdata | input | 8 | Direct write data |
| spLo | output | 8 | Low pointer byte |
| sp | output | 16 | Full stack pointer |
| busy | output | 1 | Multi-cycle operation in progress |
| memAddr | output | 16 | Memory address |
| memWdata | output | 8 | Memory write data |
| memWe | output | 1 | Memory write request |
| memRe | output | 1 | Memory read request |
| memDone | input | 1 | Memory completed the current byte |
| memRdata | input | 8 | Memory read data, valid with memDone |
| popValid | output | 1 | Popped byte strobe |
| popData | output | 8 | Popped byte |
| popDest | output | 3 | Popped byte destination: 0 PCL, 1 PCH, 2 X, 3 A, 4 CC, 5 data |

## Verification
The bench uses the default parameters: a 128-byte window whose top is 0x01FF and a 16-bit pointer. With this window, a single low-byte write reaches both wrap edges, and an interrupt entry can be made to straddle the wrap point. The bench memory model runs with a latency of zero wait cycles and then three. Three wait cycles leave room to inject commands and low-byte writes while `busy` is high.

// File: rtl/stackPkg.sv
package stackPkg;
  typedef enum logic [2:0] {
    OP_NONE = 3'd0,
    OP_PUSH = 3'd1,
    OP_POP  = 3'd2,
    OP_CALL = 3'd3,
    OP_RET  = 3'd4,
    OP_INT  = 3'd5,
    OP_IRET = 3'd6,
    OP_RSP  = 3'd7
  } stackOpE;

  localparam logic [2:0] SLOT_PCL  = 3'd0;
  localparam logic [2:0] SLOT_PCH  = 3'd1;
  localparam logic [2:0] SLOT_X    = 3'd2;
  localparam logic [2:0] SLOT_A    = 3'd3;
  localparam logic [2:0] SLOT_CC   = 3'd4;
  localparam logic [2:0] SLOT_DATA = 3'd5;
  localparam int         NSLOT     = 8;

  typedef struct packed {
    logic       loadCtx;
    logic       rstSp;
    logic       wrLo;
    logic       stepDn;
    logic       stepUp;
    logic       rdMode;
    logic [2:0] slot;
  } spCtrlS;
endpackage

// File: rtl/stackControl.sv
module stackControl
  import stackPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] opCode,
  input  logic       spLoWr,
  input  logic       memDone,
  output spCtrlS     ctrl,
  output logic       busy,
  output logic       memWe,
  output logic       memRe
);
  logic       busyQ;
  logic       rdModeQ;
  logic [2:0] slotQ;
  logic [2:0] remainQ;
  logic       accept;
  logic       startRd;
  logic [2:0] startSlot;
  logic [2:0] startRemain;

  always_comb begin
    accept      = 1'b0;
    startRd     = 1'b0;
    startSlot   = SLOT_DATA;
    startRemain = 3'd0;
    if (!busyQ) begin
      unique case (opCode)
        OP_PUSH: begin accept = 1'b1; end
        OP_POP:  begin accept = 1'b1; startRd = 1'b1; end
        OP_CALL: begin accept = 1'b1; startSlot = SLOT_PCL; startRemain = 3'd1; end
        OP_RET:  begin accept = 1'b1; startRd = 1'b1; startSlot = SLOT_PCH; startRemain = 3'd1; end
        OP_INT:  begin accept = 1'b1; startSlot = SLOT_PCL; startRemain = 3'd4; end
        OP_IRET: begin accept = 1'b1; startRd = 1'b1; startSlot = SLOT_CC; startRemain = 3'd4; end
        default: ;
      endcase
    end
  end

  always_comb begin
    ctrl.loadCtx = accept;
    ctrl.rstSp   = !busyQ && (opCode == OP_RSP);
    ctrl.wrLo    = !busyQ && spLoWr && (opCode == OP_NONE);
    ctrl.stepDn  = busyQ && !rdModeQ && memDone;
    ctrl.stepUp  = busyQ && rdModeQ && memDone;
    ctrl.rdMode  = rdModeQ;
    ctrl.slot    = slotQ;
  end

  assign busy  = busyQ;
  assign memWe = busyQ && !rdModeQ;
  assign memRe = busyQ && rdModeQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ   <= 1'b0;
      rdModeQ <= 1'b0;
      slotQ   <= SLOT_DATA;
      remainQ <= 3'd0;
    end else if (accept) begin
      busyQ   <= 1'b1;
      rdModeQ <= startRd;
      slotQ   <= startSlot;
      remainQ <= startRemain;
    end else if (busyQ && memDone) begin
      if (remainQ == 3'd0) begin
        busyQ <= 1'b0;
      end else begin
        remainQ <= remainQ - 3'd1;
        slotQ   <= rdModeQ ? slotQ - 3'd1 : slotQ + 3'd1;
      end
    end
  end
endmodule

// File: rtl/stackDatapath.sv
module stackDatapath
  import stackPkg::*;
#(
  parameter int              PTR_W     = 16,
  parameter int              DATA_W    = 8,
  parameter int              WIN_BITS  = 7,
  parameter logic [PTR_W-1:0] STACK_TOP = 16'h01FF
) (
  input  logic              clk,
  input  logic              rstN,
  input  spCtrlS            ctrl,
  input  logic [DATA_W-1:0] pushData,
  input  logic [PTR_W-1:0]  pcIn,
  input  logic [DATA_W-1:0] xIn,
  input  logic [DATA_W-1:0] aIn,
  input  logic [DATA_W-1:0] ccIn,
  input  logic [DATA_W-1:0] spLoWdata,
  input  logic [DATA_W-1:0] memRdata,
  output logic [PTR_W-1:0]  sp,
  output logic [PTR_W-1:0]  memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              popValid,
  output logic [DATA_W-1:0] popData,
  output logic [2:0]        popDest
);
  localparam int                 FIX_W   = PTR_W - WIN_BITS;
  localparam logic [FIX_W-1:0]   FIXED   = STACK_TOP[PTR_W-1:WIN_BITS];
  localparam logic [WIN_BITS-1:0] PTR_RST = STACK_TOP[WIN_BITS-1:0];
  localparam logic [WIN_BITS-1:0] ONE     = 1;

  logic [WIN_BITS-1:0] ptr;
  logic [WIN_BITS-1:0] ptrUp;
  logic [WIN_BITS-1:0] ptrDn;
  logic [DATA_W-1:0]   ctxIn [NSLOT];
  logic [DATA_W-1:0]   ctx   [NSLOT];

  assign ptrUp = ptr + ONE;
  assign ptrDn = ptr - ONE;
  assign sp    = {FIXED, ptr};

  always_comb begin
    for (int i = 0; i < NSLOT; i++) ctxIn[i] = '0;
    ctxIn[SLOT_PCL]  = pcIn[DATA_W-1:0];
    ctxIn[SLOT_PCH]  = pcIn[2*DATA_W-1:DATA_W];
    ctxIn[SLOT_X]    = xIn;
    ctxIn[SLOT_A]    = aIn;
    ctxIn[SLOT_CC]   = ccIn;
    ctxIn[SLOT_DATA] = pushData;
  end

  for (genvar g = 0; g < NSLOT; g++) begin : gCtx
    always_ff @(posedge clk) begin
      if (!rstN)             ctx[g] <= '0;
      else if (ctrl.loadCtx) ctx[g] <= ctxIn[g];
    end
  end

  assign memAddr  = ctrl.rdMode ? {FIXED, ptrUp} : sp;
  assign memWdata = ctx[ctrl.slot];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptr <= PTR_RST;
    end else if (ctrl.rstSp) begin
      ptr <= PTR_RST;
    end else if (ctrl.wrLo) begin
      ptr <= spLoWdata[WIN_BITS-1:0];
    end else if (ctrl.stepDn) begin
      ptr <= ptrDn;
    end else if (ctrl.stepUp) begin
      ptr <= ptrUp;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      popValid <= 1'b0;
      popData  <= '0;
      popDest  <= '0;
    end else begin
      popValid <= ctrl.stepUp;
      if (ctrl.stepUp) begin
        popData <= memRdata;
        popDest <= ctrl.slot;
      end
    end
  end
endmodule

// File: rtl/stackPtrUnit.sv
module stackPtrUnit
  import stackPkg::*;
#(
  parameter int              PTR_W     = 16,
  parameter int              DATA_W    = 8,
  parameter int              WIN_BITS  = 7,
  parameter logic [PTR_W-1:0] STACK_TOP = 16'h01FF
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        opCode,
  input  logic [DATA_W-1:0] pushData,
  input  logic [PTR_W-1:0]  pcIn,
  input  logic [DATA_W-1:0] xIn,
  input  logic [DATA_W-1:0] aIn,
  input  logic [DATA_W-1:0] ccIn,
  input  logic              spLoWr,
  input  logic [DATA_W-1:0] spLoWdata,
  output logic [DATA_W-1:0] spLo,
  output logic [PTR_W-1:0]  sp,
  output logic              busy,
  output logic [PTR_W-1:0]  memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              memWe,
  output logic              memRe,
  input  logic              memDone,
  input  logic [DATA_W-1:0] memRdata,
  output logic              popValid,
  output logic [DATA_W-1:0] popData,
  output logic [2:0]        popDest
);
  spCtrlS ctrl;

  stackControl uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .opCode  (opCode),
    .spLoWr  (spLoWr),
    .memDone (memDone),
    .ctrl    (ctrl),
    .busy    (busy),
    .memWe   (memWe),
    .memRe   (memRe)
  );

  stackDatapath #(
    .PTR_W     (PTR_W),
    .DATA_W    (DATA_W),
    .WIN_BITS  (WIN_BITS),
    .STACK_TOP (STACK_TOP)
  ) uPath (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .pushData  (pushData),
    .pcIn      (pcIn),
    .xIn       (xIn),
    .aIn       (aIn),
    .ccIn      (ccIn),
    .spLoWdata (spLoWdata),
    .memRdata  (memRdata),
    .sp        (sp),
    .memAddr   (memAddr),
    .memWdata  (memWdata),
    .popValid  (popValid),
    .popData   (popData),
    .popDest   (popDest)
  );

  assign spLo = sp[DATA_W-1:0];
endmodule

// File: rtl/stackPtrChecker.sv
module stackPtrChecker #(
  parameter int              PTR_W     = 16,
  parameter int              DATA_W    = 8,
  parameter int              WIN_BITS  = 7,
  parameter logic [PTR_W-1:0] STACK_TOP = 16'h01FF
) (
  input logic              clk,
  input logic              rstN,
  input logic [2:0]        opCode,
  input logic              spLoWr,
  input logic [DATA_W-1:0] spLoWdata,
  input logic [PTR_W-1:0]  sp,
  input logic              busy,
  input logic [PTR_W-1:0]  memAddr,
  input logic              memWe,
  input logic              memRe,
  input logic              memDone
);
  localparam int                  FIX_W = PTR_W - WIN_BITS;
  localparam logic [FIX_W-1:0]    FIXED = STACK_TOP[PTR_W-1:WIN_BITS];
  localparam logic [WIN_BITS-1:0] ONE   = 1;

  AST_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    (memWe || memRe) |-> memAddr[PTR_W-1:WIN_BITS] == FIXED); // R2
  AST_PUSH_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> memAddr == sp); // R3
  AST_POP_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    memRe |-> memAddr[WIN_BITS-1:0] == sp[WIN_BITS-1:0] + ONE); // R4
  AST_DEC_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (memWe && memDone) |=> sp[WIN_BITS-1:0] == $past(sp[WIN_BITS-1:0]) - ONE); // R5
  AST_INC_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (memRe && memDone) |=> sp[WIN_BITS-1:0] == $past(sp[WIN_BITS-1:0]) + ONE); // R5
  AST_RSP: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && opCode == 3'd7) |=> sp == STACK_TOP); // R6
  AST_LOW_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && spLoWr && opCode == 3'd0) |=> sp[WIN_BITS-1:0] == $past(spLoWdata[WIN_BITS-1:0])); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !memWe && !memRe); // R10
  AST_ONE_DIR: assert property (@(posedge clk) disable iff (!rstN)
    !(memWe && memRe)); // R11
  AST_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    ((memWe || memRe) && !memDone) |=> $stable(memAddr) && $stable(memWe) && $stable(memRe)); // R11
endmodule

bind stackPtrUnit stackPtrChecker #(
  .PTR_W     (PTR_W),
  .DATA_W    (DATA_W),
  .WIN_BITS  (WIN_BITS),
  .STACK_TOP (STACK_TOP)
) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .opCode    (opCode),
  .spLoWr    (spLoWr),
  .spLoWdata (spLoWdata),
  .sp        (sp),
  .busy      (busy),
  .memAddr   (memAddr),
  .memWe     (memWe),
  .memRe     (memRe),
  .memDone   (memDone)
);

// File: tb/stackPtrUnit_test.sv
module stackPtrUnit_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  opCode = 3'd0;
  logic [7:0]  pushData = 8'h00;
  logic [15:0] pcIn = 16'h0000;
  logic [7:0]  xIn = 8'h00, aIn = 8'h00, ccIn = 8'h00;
  logic        spLoWr = 1'b0;
  logic [7:0]  spLoWdata = 8'h00;
  logic [7:0]  spLo;
  logic [15:0] sp;
  logic        busy;
  logic [15:0] memAddr;
  logic [7:0]  memWdata;
  logic        memWe, memRe;
  logic        memDone = 1'b0;
  logic [7:0]  memRdata = 8'h00;
  logic        popValid;
  logic [7:0]  popData;
  logic [2:0]  popDest;

  int checks = 0;
  int errors = 0;
  int memLat = 0;
  int waitCnt = 0;
  logic [7:0] mem [128];
  logic [7:0] logData [16];
  logic [2:0] logDest [16];
  int logCnt = 0;

  stackPtrUnit uut (.*);

  always #4 clk = ~clk;

  // memory model: answers on falling edges, write lands when done rises
  always @(negedge clk) begin
    if (memDone) begin
      memDone = 1'b0;
    end else if (memWe || memRe) begin
      if (waitCnt >= memLat) begin
        waitCnt = 0;
        if (memWe) mem[memAddr[6:0]] = memWdata;
        memRdata = mem[memAddr[6:0]];
        memDone  = 1'b1;
      end else begin
        waitCnt++;
      end
    end
  end

  always @(negedge clk) begin
    if (popValid && logCnt < 16) begin
      logData[logCnt] = popData;
      logDest[logCnt] = popDest;
      logCnt++;
    end
  end

  localparam logic [35:0] VEC [8] = '{
    {4'd1, 8'hA1, 16'h01FE, 8'h00},
    {4'd1, 8'hB2, 16'h01FD, 8'h00},
    {4'd1, 8'hC3, 16'h01FC, 8'h00},
    {4'd2, 8'h00, 16'h01FD, 8'hC3},
    {4'd1, 8'hD4, 16'h01FC, 8'h00},
    {4'd2, 8'h00, 16'h01FD, 8'hD4},
    {4'd2, 8'h00, 16'h01FE, 8'hB2},
    {4'd2, 8'h00, 16'h01FF, 8'hA1}
  };

  task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] op, input logic [7:0] din);
    @(negedge clk);
    opCode = op;
    pushData = din;
    @(negedge clk);
    opCode = 3'd0;
  endtask

  task automatic runOp(input logic [2:0] op, input logic [7:0] din);
    logCnt = 0;
    issue(op, din);
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic writeLo(input logic [7:0] d);
    @(negedge clk);
    spLoWr = 1'b1;
    spLoWdata = d;
    @(negedge clk);
    spLoWr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 128; i++) mem[i] = 8'(i * 3 + 1);
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(sp == 16'h01FF, "R1 sp", sp, 16'h01FF);
    check(!busy && !memWe && !memRe, "R1 idle", {13'd0, busy, memWe, memRe}, 16'h0);
    check(spLo == 8'hFF, "R7 spLo read", {8'h0, spLo}, 16'h00FF);

    // table walk: R3 push, R4 pop
    foreach (VEC[i]) begin
      runOp(VEC[i][34:32], VEC[i][31:24]);
      check(sp == VEC[i][23:8], "R3 R4 vector sp", sp, VEC[i][23:8]);
      if (VEC[i][34:32] == 3'd2)
        check(logCnt == 1 && logData[0] == VEC[i][7:0] && logDest[0] == 3'd5,
              "R4 pop data", {logData[0], 5'd0, logDest[0]}, {VEC[i][7:0], 8'h05});
    end
    check(mem[7'h7F] == 8'hA1 && mem[7'h7E] == 8'hB2, "R3 push placement",
          {mem[7'h7F], mem[7'h7E]}, 16'hA1B2);

    // R8 call / return
    pcIn = 16'h1234;
    runOp(3'd3, 8'h00);
    check(sp == 16'h01FD, "R8 call sp", sp, 16'h01FD);
    check(mem[7'h7F] == 8'h34 && mem[7'h7E] == 8'h12, "R8 call order",
          {mem[7'h7F], mem[7'h7E]}, 16'h3412);
    pcIn = 16'h0000;
    runOp(3'd4, 8'h00);
    check(sp == 16'h01FF, "R8 ret sp", sp, 16'h01FF);
    check(logCnt == 2 && logData[0] == 8'h12 && logDest[0] == 3'd1 &&
          logData[1] == 8'h34 && logDest[1] == 3'd0, "R8 ret order",
          {logData[0], logData[1]}, 16'h1234);

    // R9 interrupt entry / return
    pcIn = 16'hABCD; xIn = 8'h11; aIn = 8'h22; ccIn = 8'h33;
    runOp(3'd5, 8'h00);
    check(sp == 16'h01FA, "R9 int sp", sp, 16'h01FA);
    check(mem[7'h7F] == 8'hCD && mem[7'h7E] == 8'hAB && mem[7'h7D] == 8'h11 &&
          mem[7'h7C] == 8'h22 && mem[7'h7B] == 8'h33, "R9 int frame",
          {mem[7'h7F], mem[7'h7B]}, 16'hCD33);
    runOp(3'd6, 8'h00);
    check(sp == 16'h01FF, "R9 iret sp", sp, 16'h01FF);
    check(logCnt == 5 && logDest[0] == 3'd4 && logData[0] == 8'h33 &&
          logDest[1] == 3'd3 && logData[1] == 8'h22 && logDest[2] == 3'd2 &&
          logData[2] == 8'h11 && logDest[3] == 3'd1 && logData[3] == 8'hAB &&
          logDest[4] == 3'd0 && logData[4] == 8'hCD, "R9 iret order",
          {logData[0], logData[4]}, 16'h33CD);

    // R7 low write, bit 7 has no effect
    writeLo(8'h05);
    check(sp == 16'h0185 && spLo == 8'h85, "R7 low write", sp, 16'h0185);
    // R6 stack reset
    issue(3'd7, 8'h00);
    check(sp == 16'h01FF, "R6 rsp", sp, 16'h01FF);

    // R5 wrap down then up
    writeLo(8'h80);
    check(sp == 16'h0180, "R7 low write bottom", sp, 16'h0180);
    runOp(3'd1, 8'h77);
    check(sp == 16'h01FF && mem[7'h00] == 8'h77, "R5 wrap down", sp, 16'h01FF);
    runOp(3'd2, 8'h00);
    check(sp == 16'h0180 && logData[0] == 8'h77, "R5 wrap up", sp, 16'h0180);

    // R5 interrupt frame straddling the window edge
    writeLo(8'h02);
    pcIn = 16'h5566; xIn = 8'h44; aIn = 8'h99; ccIn = 8'hEE;
    runOp(3'd5, 8'h00);
    check(sp == 16'h01FD, "R5 int straddle sp", sp, 16'h01FD);
    check(mem[7'h02] == 8'h66 && mem[7'h00] == 8'h44 && mem[7'h7F] == 8'h99 &&
          mem[7'h7E] == 8'hEE, "R5 int straddle frame", {mem[7'h7F], mem[7'h7E]}, 16'h99EE);

    // R10 requests during busy are ignored; R11 with slow memory
    memLat = 3;
    issue(3'd7, 8'h00);
    pcIn = 16'h0F0E; xIn = 8'h01; aIn = 8'h02; ccIn = 8'h03;
    logCnt = 0;
    issue(3'd5, 8'h00);
    check(busy == 1'b1, "R10 busy high", {15'd0, busy}, 16'h1);
    @(negedge clk); opCode = 3'd1; pushData = 8'hFE;
    @(negedge clk); opCode = 3'd7;
    @(negedge clk); opCode = 3'd0; spLoWr = 1'b1; spLoWdata = 8'h10;
    @(negedge clk); spLoWr = 1'b0;
    while (busy) @(negedge clk);
    check(sp == 16'h01FA, "R10 ignored while busy", sp, 16'h01FA);
    check(mem[7'h7B] == 8'h03 && mem[7'h7A] != 8'hFE, "R10 no extra push",
          {mem[7'h7B], mem[7'h7A]}, 16'h0300);
    runOp(3'd6, 8'h00);
    check(sp == 16'h01FF && logCnt == 5 && logData[4] == 8'h0E, "R11 slow iret",
          sp, 16'h01FF);
    runOp(3'd2, 8'h00);
    check(sp == 16'h0180 && logCnt == 1, "R11 slow pop wrap", sp, 16'h0180);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule